// File: doc/BRIEF.md
# Mirrored memory address translator

This block turns a CPU byte address into an offset inside a single flat, gap-free physical store. It also steers the bytes of 1-, 2- and 4-byte accesses onto little-endian lanes. Only the low 24 bits of the incoming address are decoded. Those 24 bits fall into one of four regions:

- a ROM window below 0x100000, which repeats every ROM-size bytes;
- an external RAM chunk, from 0x100000 up to a configurable low-end limit;
- a high region, from a configurable high-start limit to the top of the space;
- a hole between the low-end and high-start limits.

The high region is packed into the store directly behind the ROM and the external chunk. Inside the top two 4 KB pages of the high region, each page exposes only its first 1 KB, which repeats four times across the page.

An access that lands in the hole raises a fault flag. Such an access is steered to a harmless location: offset zero, with no byte lanes enabled. A faulting write therefore changes nothing, and a faulting read returns zero.

The request is registered once. The translated offset, fault flag, lane enables and packed write data all appear together on the cycle after the request. The store answers combinationally at the registered offset, and the block zero-extends the read data by the registered access size. The three configuration inputs are expected to be held stable while accesses are in flight. The low-end limit must be at least 0x100000, and the ROM size must be a power of two.

Top module: `mirror_xlat`

## Requirements
- R1: Address bits above bit 23 have no effect: two requests that differ only in those bits give identical offsets, faults and lanes.
- R2: An address below 0x100000 maps to offset (address AND (ROM size − 1)), so the ROM repeats every ROM-size bytes.
- R3: An address from 0x100000 up to, but not including, the low-end limit maps to offset (address − 0x100000 + ROM size).
- R4: An address at or above the high-start limit maps to offset (masked address − high start + ROM size + low end − 0x100000). The masked address is the address itself outside the top two pages.
- R5: For addresses 0xFFE000–0xFFEFFF and 0xFFF000–0xFFFFFF, bits 11:10 are cleared before the high-region mapping, so each page's first 1 KB repeats four times.
- R6: An address at or above the low-end limit and below the high-start limit sets acc_fault, forces acc_offset to 0 and clears every bit of acc_byte_en. A faulting write therefore cannot modify the store.
- R7: req_size encodes 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. acc_byte_en is 0001, 0011 or 1111 respectively, with bit k enabling the byte at offset + k. acc_wdata lane k carries req_wdata bits 8k+7:8k when lane k is enabled and zero otherwise, so byte 0 carries bits 7:0.
- R8: rsp_data is mem_rdata zero-extended to the registered size: bits 7:0 for 1 byte, bits 15:0 for 2 bytes, all 32 bits for 4 bytes. It is all zeros when acc_fault is set.
- R9: acc_valid, acc_write, acc_offset, acc_fault, acc_byte_en and acc_wdata reflect a request exactly one clock after req_valid is sampled high. acc_valid is low on the cycle after req_valid is sampled low.
- R10: While rst_n is low, acc_valid, acc_fault and acc_byte_en are cleared on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (R7) |
| req_addr | input | 32 | CPU byte address; only bits 23:0 are used |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| cfg_rom_size | input | 24 | ROM size in bytes, a power of two |
| cfg_low_end | input | 24 | End of the external RAM chunk, exclusive; at least 0x100000 |
| cfg_high_start | input | 24 | First address of the high region |
| mem_rdata | input | 32 | Store read data at acc_offset, lane k = byte at offset + k |
| acc_valid | output | 1 | Translated access strobe |
| acc_write | output | 1 | Registered write flag |
| acc_offset | output | 24 | Offset into the flat physical store |
| acc_fault | output | 1 | Address fell in the hole |
| acc_byte_en | output | 4 | Lane enables, zero on a fault |
| acc_wdata | output | 32 | Lane-steered write data |
| rsp_data | output | 32 | Size-extended read data, zero on a fault |

## Verification
Fault suppression and lane packing act in the same cycle. A word-sized write into the hole produces both a fault and a full set of lane enables, and the fault has to win. The bench issues 4-byte writes and reads at the first address of the hole and at the last address below the high region. It expects zero enables, zero offset and a zero response on those accesses. Back-to-back requests that alternate between mapped and unmapped addresses show that a fault on one access does not leak into its neighbours. The scoreboard also records the cycle each expectation is due, so the one-clock latency is checked on every access.

// File: rtl/mxlat_pkg.sv
package mxlat_pkg;
  typedef enum logic [1:0] {
    RG_ROM  = 2'd0,
    RG_EXT  = 2'd1,
    RG_HIGH = 2'd2,
    RG_HOLE = 2'd3
  } mx_region_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } mx_size_e;

  // number of bytes touched by a size code (R7)
  function automatic int unsigned size_bytes(logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/mx_region_dec.sv
module mx_region_dec
  import mxlat_pkg::*;
#(
  parameter int AW = 24,
  parameter logic [AW-1:0] LOW_BASE = 24'h100000
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] low_end,
  input  logic [AW-1:0] high_start,
  output mx_region_e    region
);
  // priority: ROM window, external chunk, high region, otherwise hole
  function automatic mx_region_e classify(logic [AW-1:0] a, logic [AW-1:0] le,
                                          logic [AW-1:0] hs);
    if (a < LOW_BASE)    return RG_ROM;
    else if (a < le)     return RG_EXT;
    else if (a >= hs)    return RG_HIGH;
    else                 return RG_HOLE;
  endfunction

  assign region = classify(addr, low_end, high_start);
endmodule

// File: rtl/mx_offset_calc.sv
module mx_offset_calc
  import mxlat_pkg::*;
#(
  parameter int AW = 24,
  parameter logic [AW-1:0] LOW_BASE = 24'h100000,
  parameter int PAGE_BITS = 12,
  parameter int WIN_BITS = 10,
  parameter int MIRROR_PAGES = 2
) (
  input  logic [AW-1:0] addr,
  input  mx_region_e    region,
  input  logic [AW-1:0] rom_size,
  input  logic [AW-1:0] low_end,
  input  logic [AW-1:0] high_start,
  output logic [AW-1:0] offset,
  output logic          win_hit
);
  localparam int PN_W = AW - PAGE_BITS;
  localparam logic [PN_W-1:0] FIRST_MIRROR_PAGE = {PN_W{1'b1}} - PN_W'(MIRROR_PAGES - 1);
  localparam logic [AW-1:0] WIN_CLEAR =
    ~(((AW'(1) << PAGE_BITS) - 1) ^ ((AW'(1) << WIN_BITS) - 1));

  logic [AW-1:0] high_addr;

  // top pages keep only their first window, repeated across the page (R5)
  generate
    if (MIRROR_PAGES > 0) begin : g_mirror
      assign win_hit   = addr[AW-1:PAGE_BITS] >= FIRST_MIRROR_PAGE;
      assign high_addr = win_hit ? (addr & WIN_CLEAR) : addr;
    end else begin : g_flat
      assign win_hit   = 1'b0;
      assign high_addr = addr;
    end
  endgenerate

  function automatic logic [AW-1:0] rom_off(logic [AW-1:0] a, logic [AW-1:0] rs);
    return a & (rs - AW'(1));
  endfunction

  function automatic logic [AW-1:0] ext_off(logic [AW-1:0] a, logic [AW-1:0] rs);
    return a - LOW_BASE + rs;
  endfunction

  function automatic logic [AW-1:0] high_off(logic [AW-1:0] a, logic [AW-1:0] rs,
                                             logic [AW-1:0] le, logic [AW-1:0] hs);
    logic [AW-1:0] base;
    base = rs + (le - LOW_BASE);
    return a - hs + base;
  endfunction

  always_comb begin
    case (region)
      RG_ROM:  offset = rom_off(addr, rom_size);
      RG_EXT:  offset = ext_off(addr, rom_size);
      RG_HIGH: offset = high_off(high_addr, rom_size, low_end, high_start);
      default: offset = '0;
    endcase
  end
endmodule

// File: rtl/mx_lane_pack.sv
module mx_lane_pack
  import mxlat_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]      wr_size,
  input  logic            wr_fault,
  input  logic [DW-1:0]   wr_data,
  output logic [DW/8-1:0] lane_en,
  output logic [DW-1:0]   lane_data,
  input  logic [1:0]      rd_size,
  input  logic            rd_fault,
  input  logic [DW-1:0]   rd_raw,
  output logic [DW-1:0]   rd_data
);
  localparam int NB = DW / 8;

  generate
    for (genvar k = 0; k < NB; k++) begin : g_lane
      logic wr_on, rd_on;
      assign wr_on = !wr_fault && (k < size_bytes(wr_size));
      assign rd_on = !rd_fault && (k < size_bytes(rd_size));
      assign lane_en[k]           = wr_on;
      assign lane_data[8*k +: 8]  = wr_on ? wr_data[8*k +: 8] : 8'h00;
      assign rd_data[8*k +: 8]    = rd_on ? rd_raw[8*k +: 8]  : 8'h00;
    end
  endgenerate
endmodule

// File: rtl/mirror_xlat.sv
module mirror_xlat
  import mxlat_pkg::*;
#(
  parameter int IN_W = 32,
  parameter int AW = 24,
  parameter int DW = 32,
  parameter logic [AW-1:0] LOW_BASE = 24'h100000,
  parameter int PAGE_BITS = 12,
  parameter int WIN_BITS = 10,
  parameter int MIRROR_PAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [IN_W-1:0]   req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [AW-1:0]     cfg_rom_size,
  input  logic [AW-1:0]     cfg_low_end,
  input  logic [AW-1:0]     cfg_high_start,
  input  logic [DW-1:0]     mem_rdata,
  output logic              acc_valid,
  output logic              acc_write,
  output logic [AW-1:0]     acc_offset,
  output logic              acc_fault,
  output logic [DW/8-1:0]   acc_byte_en,
  output logic [DW-1:0]     acc_wdata,
  output logic [DW-1:0]     rsp_data
);
  localparam int NB = DW / 8;

  // named internal events for the checker
  logic [AW-1:0]   cpu_addr;
  mx_region_e      nxt_region;
  logic            nxt_fault;
  logic [AW-1:0]   nxt_offset;
  logic            nxt_win_hit;
  logic [NB-1:0]   nxt_lanes;
  logic [DW-1:0]   nxt_wdata;
  mx_region_e      acc_region;
  logic [1:0]      acc_size;

  assign cpu_addr  = req_addr[AW-1:0];
  assign nxt_fault = (nxt_region == RG_HOLE);

  mx_region_dec #(.AW(AW), .LOW_BASE(LOW_BASE)) u_dec (
    .addr       (cpu_addr),
    .low_end    (cfg_low_end),
    .high_start (cfg_high_start),
    .region     (nxt_region)
  );

  mx_offset_calc #(
    .AW(AW), .LOW_BASE(LOW_BASE), .PAGE_BITS(PAGE_BITS),
    .WIN_BITS(WIN_BITS), .MIRROR_PAGES(MIRROR_PAGES)
  ) u_off (
    .addr       (cpu_addr),
    .region     (nxt_region),
    .rom_size   (cfg_rom_size),
    .low_end    (cfg_low_end),
    .high_start (cfg_high_start),
    .offset     (nxt_offset),
    .win_hit    (nxt_win_hit)
  );

  mx_lane_pack #(.DW(DW)) u_lanes (
    .wr_size   (req_size),
    .wr_fault  (nxt_fault),
    .wr_data   (req_wdata),
    .lane_en   (nxt_lanes),
    .lane_data (nxt_wdata),
    .rd_size   (acc_size),
    .rd_fault  (acc_fault),
    .rd_raw    (mem_rdata),
    .rd_data   (rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid   <= 1'b0;
      acc_fault   <= 1'b0;
      acc_byte_en <= '0;
      acc_write   <= 1'b0;
      acc_offset  <= '0;
      acc_wdata   <= '0;
      acc_size    <= 2'd0;
      acc_region  <= RG_ROM;
    end else begin
      acc_valid <= req_valid;
      if (req_valid) begin
        acc_write   <= req_write;
        acc_offset  <= nxt_offset;
        acc_fault   <= nxt_fault;
        acc_byte_en <= nxt_lanes;
        acc_wdata   <= nxt_wdata;
        acc_size    <= req_size;
        acc_region  <= nxt_region;
      end else begin
        acc_byte_en <= '0;
        acc_fault   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mirror_xlat_chk.sv
module mirror_xlat_chk #(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter logic [AW-1:0] LOW_BASE = 24'h100000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            acc_valid,
  input logic            acc_fault,
  input logic [AW-1:0]   acc_offset,
  input logic [DW/8-1:0] acc_byte_en,
  input logic [DW-1:0]   rsp_data,
  input logic [1:0]      acc_region,
  input logic [AW-1:0]   cfg_rom_size,
  input logic [AW-1:0]   cfg_low_end
);
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> acc_valid);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !acc_valid);

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (!acc_valid && !acc_fault && acc_byte_en == '0));

  assert_hole_dummy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_fault) |-> (acc_byte_en == '0 && acc_offset == '0));

  assert_rom_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_region == 2'd0) |-> (acc_offset < cfg_rom_size));

  assert_ext_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_region == 2'd1) |->
      (acc_offset >= cfg_rom_size &&
       acc_offset < cfg_rom_size + (cfg_low_end - LOW_BASE)));

  assert_lanes_contig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> ((acc_byte_en & (acc_byte_en + 1'b1)) == '0));

  assert_fault_rdzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_fault) |-> (rsp_data == '0));
endmodule

bind mirror_xlat mirror_xlat_chk #(.AW(AW), .DW(DW), .LOW_BASE(LOW_BASE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .acc_valid    (acc_valid),
  .acc_fault    (acc_fault),
  .acc_offset   (acc_offset),
  .acc_byte_en  (acc_byte_en),
  .rsp_data     (rsp_data),
  .acc_region   (acc_region),
  .cfg_rom_size (cfg_rom_size),
  .cfg_low_end  (cfg_low_end)
);

// File: tb/mirror_xlat_bench.sv
`timescale 1ns/1ps
module mirror_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [23:0] cfg_rom_size = 24'h040000;
  logic [23:0] cfg_low_end = 24'h180000;
  logic [23:0] cfg_high_start = 24'hFF0000;
  logic [31:0] mem_rdata;
  logic        acc_valid, acc_write, acc_fault;
  logic [23:0] acc_offset;
  logic [3:0]  acc_byte_en;
  logic [31:0] acc_wdata, rsp_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  typedef struct packed {
    logic [23:0] off;
    logic        flt;
    logic        wr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [1:0]  sz;
    logic [31:0] due;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // store model: a fixed pattern derived from the offset
  function automatic logic [31:0] store_word(logic [23:0] o);
    return {o[7:0] ^ 8'hC3, o[15:8], o[23:16], o[7:0]};
  endfunction
  assign mem_rdata = store_word(acc_offset);

  mirror_xlat u_mirror_xlat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_rom_size(cfg_rom_size), .cfg_low_end(cfg_low_end),
    .cfg_high_start(cfg_high_start), .mem_rdata(mem_rdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_offset(acc_offset),
    .acc_fault(acc_fault), .acc_byte_en(acc_byte_en), .acc_wdata(acc_wdata),
    .rsp_data(rsp_data)
  );

  // reference mapping in plain integer arithmetic
  task automatic model(input logic [31:0] raw, output logic [23:0] off, output logic flt);
    longint unsigned a, rom, le, hs;
    a = raw % (64'd1 << 24);
    rom = cfg_rom_size; le = cfg_low_end; hs = cfg_high_start;
    flt = 1'b0; off = '0;
    if (a < 64'h100000) off = 24'(a % rom);
    else if (a < le) off = 24'(a - 64'h100000 + rom);
    else if (a >= hs) begin
      if (a / 4096 >= 64'hFFE) a = (a / 4096) * 4096 + (a % 1024);
      off = 24'(a - hs + rom + (le - 64'h100000));
    end else flt = 1'b1;
  endtask

  task automatic issue(input logic [31:0] addr, input logic wr, input logic [1:0] sz,
                       input logic [31:0] wd, input string tag);
    exp_t e;
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
    model(addr, e.off, e.flt);
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    e.be = e.flt ? 4'b0000 : 4'((1 << n) - 1);
    for (int k = 0; k < 4; k++) e.wd[8*k +: 8] = e.be[k] ? wd[8*k +: 8] : 8'h00;
    e.wr = wr; e.sz = sz; e.due = 32'(cyc + 1);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor: compare each result against the front of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && acc_valid) begin
        exp_t e;
        string t;
        logic [31:0] er;
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R9 unexpected acc_valid: actual 1 expected 0");
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          er = e.flt ? 32'h0 : (e.sz == 2'd0) ? {24'h0, store_word(e.off)[7:0]} :
               (e.sz == 2'd1) ? {16'h0, store_word(e.off)[15:0]} : store_word(e.off);
          if (acc_offset !== e.off || acc_fault !== e.flt || acc_byte_en !== e.be ||
              acc_wdata !== e.wd || acc_write !== e.wr || rsp_data !== er ||
              32'(cyc) !== e.due) begin
            fails++;
            $display("FAIL %s: actual off=%h flt=%b be=%b wd=%h wr=%b rd=%h cyc=%0d expected off=%h flt=%b be=%b wd=%h wr=%b rd=%h cyc=%0d",
                     t, acc_offset, acc_fault, acc_byte_en, acc_wdata, acc_write, rsp_data, cyc,
                     e.off, e.flt, e.be, e.wd, e.wr, er, e.due);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (acc_valid !== 1'b0 || acc_fault !== 1'b0 || acc_byte_en !== 4'b0) begin
      fails++;
      $display("FAIL R10 reset: actual v=%b f=%b be=%b expected 0 0 0000", acc_valid, acc_fault, acc_byte_en);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // configuration A: 256 KB ROM, chunk to 0x180000, high from 0xFF0000
    issue(32'h0000_0010, 1'b0, 2'd0, 32'h0, "R2 rom base");
    issue(32'h0004_0010, 1'b0, 2'd0, 32'h0, "R2 rom mirror");
    issue(32'h000F_FFFF, 1'b0, 2'd0, 32'h0, "R2 rom top");
    issue(32'h0010_0000, 1'b0, 2'd2, 32'h0, "R3 ext first");
    issue(32'h0017_FFFC, 1'b0, 2'd2, 32'h0, "R3 ext last word");
    issue(32'h0018_0000, 1'b0, 2'd2, 32'h0, "R6 hole first read");
    issue(32'h0010_0004, 1'b0, 2'd1, 32'h0, "R8 half read after fault");
    issue(32'h00FE_FFFF, 1'b1, 2'd2, 32'hDEAD_BEEF, "R6 hole last write");
    issue(32'h00FF_0000, 1'b0, 2'd2, 32'h0, "R4 high first");
    issue(32'h00FF_D123, 1'b0, 2'd0, 32'h0, "R4 high mid");
    issue(32'h00FF_E400, 1'b0, 2'd0, 32'h0, "R5 page E mirror");
    issue(32'h00FF_EC05, 1'b0, 2'd1, 32'h0, "R5 page E last window");
    issue(32'h00FF_F7FF, 1'b0, 2'd0, 32'h0, "R5 page F mirror");
    issue(32'hAB00_0010, 1'b0, 2'd0, 32'h0, "R1 upper bits rom");
    issue(32'h12FF_0004, 1'b0, 2'd2, 32'h0, "R1 upper bits high");
    issue(32'h5A18_0000, 1'b0, 2'd0, 32'h0, "R1 upper bits hole");
    issue(32'h0000_0100, 1'b1, 2'd0, 32'h1122_3344, "R7 byte write");
    issue(32'h0010_0200, 1'b1, 2'd1, 32'h1122_3344, "R7 half write");
    issue(32'h00FF_0300, 1'b1, 2'd2, 32'h1122_3344, "R7 word write");
    issue(32'h0000_0104, 1'b1, 2'd3, 32'hCAFE_F00D, "R7 size3 as word");
    issue(32'h0012_3456, 1'b0, 2'd1, 32'h0, "R8 half read");
    idle(3);
    issue(32'h0000_0020, 1'b0, 2'd2, 32'h0, "R9 after idle gap");
    idle(3);

    // configuration B: 64 KB ROM, no external chunk, high region = top two pages
    cfg_rom_size = 24'h010000; cfg_low_end = 24'h100000; cfg_high_start = 24'hFFE000;
    idle(2);
    issue(32'h000A_BCDE, 1'b0, 2'd0, 32'h0, "R2 small rom mirror");
    issue(32'h0010_0000, 1'b1, 2'd2, 32'h0BAD_0BAD, "R6 empty chunk faults");
    issue(32'h00FF_DFFF, 1'b0, 2'd2, 32'h0, "R6 below high start");
    issue(32'h00FF_E000, 1'b0, 2'd2, 32'h0, "R4 high start packed");
    issue(32'h00FF_FFFF, 1'b0, 2'd0, 32'h0, "R5 top byte mirror");
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9 drain: actual %0d pending expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule